// File: doc/BRIEF.md
# DDR PHY Training Step Sequencer

This block walks one DDR memory channel through its physical-layer training after reset. Software writes a command word, presented here as a set of field inputs qualified by a write strobe. A write with the start field set launches up to four training steps in a fixed order. The order is receive-enable, then read DQ-DQS, then write leveling, then write DQ-DQS. A step whose skip bit is set is passed over. Each step that runs is a handshake with an external trainer: a one-cycle start pulse goes out, and the trainer answers with a done or a fail response. A programmable timeout watches for the answer.

A timed-out step is flagged and the sequence moves on. The one exception is when stop-on-fail is set and the separate auto-reset-disable input is low; the sequencer then halts and returns to idle. The same command word also carries several other controls:

- one-shot ZQ long calibration and RCOMP requests to a selected rank
- a one-cycle pulse that resets the TX/RX FIFO pointers and bubble generators
- a bit that gates the read-return early-valid signal
- the CKE drive control, which is locked once initialization is marked done

Top module: `phy_train_seq`

## Requirements
- R1: After reset, busy, halted, step_fail, trn_start, zq_req, rcomp_req, fifo_rst and cke_oe are all 0, cke is all zeros, and rx_valid_out follows rx_valid_in.
- R2: Steps are numbered on trn_step as 0 receive-enable, 1 read DQ-DQS, 2 write leveling, 3 write DQ-DQS. Unmasked steps run in ascending order. Each one begins with trn_start high for exactly one cycle. The next step begins only after the current one has received a response or has timed out.
- R3: Bit i of cmd_skip skips step i. A skipped step produces no trn_start pulse and takes exactly one cycle.
- R4: The timeout counter is reloaded from cmd_timeout, as latched by the start write, at every step launch. A value of 0 means 2^TW-1 cycles. A response is accepted in any of the first T cycles after the step's launch, counting the trn_start cycle as the first. Without a response, the step times out at the end of cycle T.
- R5: A timeout while the latched stop-on-fail is 1 and auto_rst_dis is 0 sets halted and that step's step_fail bit, drops busy, and launches no later step.
- R6: A fail response sets that step's step_fail bit. So does a timeout when the halt condition of R5 is false. In both cases the sequence continues with the next step.
- R7: busy rises on the cycle after an accepted start write and falls after the last step completes or after a halt. The busy time equals the sum of 1 per skipped step and 1+k per launched step, where k is the cycle of the response or of the timeout. A start write while busy is ignored. An accepted start clears step_fail and halted.
- R8: A write with cmd_zq or cmd_rcomp set raises zq_req or rcomp_req, respectively, for one cycle on the following cycle. On that same cycle cal_rank holds the written cmd_rank.
- R9: A write with cmd_fifo_rst set produces a one-cycle fifo_rst pulse on the following cycle.
- R10: While the last written cmd_ignore_rx is 1, rx_valid_out is 0. Otherwise it equals rx_valid_in.
- R11: A write while init_done is 0 loads cmd_cke into the CKE drive state. When that state is 1, cke_oe is 1 and every cke bit is 1. When it is 0, cke_oe and all cke bits are 0. A write while init_done is 1 leaves the CKE drive state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_start | input | 1 | Start the training sequence |
| cmd_skip | input | 4 | Per-step skip mask, bit i for step i |
| cmd_stop_on_fail | input | 1 | Halt on timeout request |
| cmd_timeout | input | TW | Step timeout in cycles, 0 means maximum |
| cmd_zq | input | 1 | Request ZQ long calibration |
| cmd_rcomp | input | 1 | Request RCOMP |
| cmd_rank | input | RANK_W | Target rank for calibration requests |
| cmd_fifo_rst | input | 1 | Request FIFO pointer reset pulse |
| cmd_ignore_rx | input | 1 | Gate read-return valid |
| cmd_cke | input | 1 | CKE drive enable |
| auto_rst_dis | input | 1 | Auto-reset-disable; when high, timeouts never halt |
| init_done | input | 1 | Initialization complete; locks CKE control |
| trn_start | output | 1 | One-cycle step start to trainer |
| trn_step | output | 2 | Current step number |
| trn_done | input | 1 | Trainer reports success |
| trn_fail | input | 1 | Trainer reports failure |
| zq_req | output | 1 | ZQ long calibration request pulse |
| rcomp_req | output | 1 | RCOMP request pulse |
| cal_rank | output | RANK_W | Rank for calibration requests |
| fifo_rst | output | 1 | TX/RX FIFO pointer and bubble generator reset pulse |
| rx_valid_in | input | 1 | Early valid from RX FIFOs |
| rx_valid_out | output | 1 | Gated early valid to read-return path |
| cke | output | NCKE | CKE levels |
| cke_oe | output | 1 | CKE driven by this block |
| busy | output | 1 | Sequence in progress |
| halted | output | 1 | Sticky: sequence stopped on timeout |
| step_fail | output | 4 | Sticky per-step failure flags |

## Verification
Several properties are checked on every cycle:
- trn_start is a single-cycle pulse and only occurs while busy.
- A halt leaves the block idle, and only happens with auto-reset-disable low.
- Each calibration request or FIFO reset pulse traces back to a write with the matching bit.
- busy only rises after a start write.
- cke_oe cannot move while init_done is high.

Some behaviour can only be shown by the bench's scenarios. These are the ascending launch order under every skip mask, the exact busy duration, and the sticky fail flags. The same holds for the boundary between a response in the last allowed cycle and a timeout, and for the difference between halting and continuing after a timeout. So too for a start write that arrives mid-sequence.

// File: rtl/phy_train_seq.sv
module phy_train_seq #(
  parameter int TW     = 8,
  parameter int RANK_W = 2,
  parameter int NCKE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              cmd_start,
  input  logic [3:0]        cmd_skip,
  input  logic              cmd_stop_on_fail,
  input  logic [TW-1:0]     cmd_timeout,
  input  logic              cmd_zq,
  input  logic              cmd_rcomp,
  input  logic [RANK_W-1:0] cmd_rank,
  input  logic              cmd_fifo_rst,
  input  logic              cmd_ignore_rx,
  input  logic              cmd_cke,
  input  logic              auto_rst_dis,
  input  logic              init_done,
  output logic              trn_start,
  output logic [1:0]        trn_step,
  input  logic              trn_done,
  input  logic              trn_fail,
  output logic              zq_req,
  output logic              rcomp_req,
  output logic [RANK_W-1:0] cal_rank,
  output logic              fifo_rst,
  input  logic              rx_valid_in,
  output logic              rx_valid_out,
  output logic [NCKE-1:0]   cke,
  output logic              cke_oe,
  output logic              busy,
  output logic              halted,
  output logic [3:0]        step_fail
);
  localparam logic [TW-1:0] TMAX = {TW{1'b1}};

  logic          busy_q, wait_q, start_q, halt_q, sof_q;
  logic [1:0]    step_q;
  logic [3:0]    skip_q, fail_q;
  logic [TW-1:0] tmo_q, timer_q;
  logic          zq_q, rc_q, fifo_q, ign_q, cke_q;
  logic [RANK_W-1:0] rank_q;

  wire accept   = cmd_we && cmd_start && !busy_q;
  wire last     = (step_q == 2'd3);
  wire resp     = wait_q && (trn_done || trn_fail);
  wire expire   = wait_q && !resp && (timer_q == TW'(1));
  wire halt_now = expire && sof_q && !auto_rst_dis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wait_q  <= 1'b0;
      start_q <= 1'b0;
      halt_q  <= 1'b0;
      sof_q   <= 1'b0;
      step_q  <= '0;
      skip_q  <= '0;
      fail_q  <= '0;
      tmo_q   <= '0;
      timer_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        wait_q <= 1'b0;
        step_q <= '0;
        skip_q <= cmd_skip;
        sof_q  <= cmd_stop_on_fail;
        tmo_q  <= cmd_timeout;
        fail_q <= '0;
        halt_q <= 1'b0;
      end else if (busy_q) begin
        if (!wait_q) begin
          if (skip_q[step_q]) begin
            if (last) busy_q <= 1'b0;
            else      step_q <= step_q + 2'd1;
          end else begin
            start_q <= 1'b1;
            wait_q  <= 1'b1;
            timer_q <= (tmo_q == '0) ? TMAX : tmo_q;
          end
        end else if (resp || expire) begin
          wait_q <= 1'b0;
          if (trn_fail || expire) fail_q[step_q] <= 1'b1;
          if (halt_now) begin
            halt_q <= 1'b1;
            busy_q <= 1'b0;
          end else if (last) begin
            busy_q <= 1'b0;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end else begin
          timer_q <= timer_q - TW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zq_q   <= 1'b0;
      rc_q   <= 1'b0;
      fifo_q <= 1'b0;
      ign_q  <= 1'b0;
      cke_q  <= 1'b0;
      rank_q <= '0;
    end else begin
      zq_q   <= cmd_we && cmd_zq;
      rc_q   <= cmd_we && cmd_rcomp;
      fifo_q <= cmd_we && cmd_fifo_rst;
      if (cmd_we && (cmd_zq || cmd_rcomp)) rank_q <= cmd_rank;
      if (cmd_we) ign_q <= cmd_ignore_rx;
      if (cmd_we && !init_done) cke_q <= cmd_cke;
    end
  end

  assign trn_start    = start_q;
  assign trn_step     = step_q;
  assign busy         = busy_q;
  assign halted       = halt_q;
  assign step_fail    = fail_q;
  assign zq_req       = zq_q;
  assign rcomp_req    = rc_q;
  assign cal_rank     = rank_q;
  assign fifo_rst     = fifo_q;
  assign rx_valid_out = rx_valid_in && !ign_q;
  assign cke          = {NCKE{cke_q}};
  assign cke_oe       = cke_q;

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trn_start |=> !trn_start);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trn_start |-> busy);
  assert_halt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> !busy);
  assert_halt_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(!auto_rst_dis));
  assert_busy_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_we && cmd_start));
  assert_zq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zq_req |-> $past(cmd_we && cmd_zq));
  assert_rcomp_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rcomp_req |-> $past(cmd_we && cmd_rcomp));
  assert_fifo_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |-> $past(cmd_we && cmd_fifo_rst));
  assert_cke_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> $stable(cke_oe));
endmodule

// File: tb/phy_train_seq_tb.sv
`timescale 1ns/1ps
module phy_train_seq_tb;
  localparam int TW = 8, RANK_W = 2, NCKE = 2;

  logic clk = 0, rst_n = 0;
  logic cmd_we = 0, cmd_start = 0, cmd_stop_on_fail = 0;
  logic [3:0] cmd_skip = 0;
  logic [TW-1:0] cmd_timeout = 0;
  logic cmd_zq = 0, cmd_rcomp = 0, cmd_fifo_rst = 0, cmd_ignore_rx = 0, cmd_cke = 0;
  logic [RANK_W-1:0] cmd_rank = 0;
  logic auto_rst_dis = 0, init_done = 0;
  logic trn_start, trn_done = 0, trn_fail = 0;
  logic [1:0] trn_step;
  logic zq_req, rcomp_req, fifo_rst, rx_valid_in = 0, rx_valid_out, cke_oe, busy, halted;
  logic [RANK_W-1:0] cal_rank;
  logic [NCKE-1:0] cke;
  logic [3:0] step_fail;

  phy_train_seq #(.TW(TW), .RANK_W(RANK_W), .NCKE(NCKE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_start(cmd_start), .cmd_skip(cmd_skip),
    .cmd_stop_on_fail(cmd_stop_on_fail), .cmd_timeout(cmd_timeout), .cmd_zq(cmd_zq),
    .cmd_rcomp(cmd_rcomp), .cmd_rank(cmd_rank), .cmd_fifo_rst(cmd_fifo_rst),
    .cmd_ignore_rx(cmd_ignore_rx), .cmd_cke(cmd_cke), .auto_rst_dis(auto_rst_dis),
    .init_done(init_done), .trn_start(trn_start), .trn_step(trn_step), .trn_done(trn_done),
    .trn_fail(trn_fail), .zq_req(zq_req), .rcomp_req(rcomp_req), .cal_rank(cal_rank),
    .fifo_rst(fifo_rst), .rx_valid_in(rx_valid_in), .rx_valid_out(rx_valid_out),
    .cke(cke), .cke_oe(cke_oe), .busy(busy), .halted(halted), .step_fail(step_fail));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int kind [4];
  int dly = 2;
  int log_s [8];
  int nlog = 0;
  int k = 0, cur = 0;
  bit pend = 0, start_twice = 0;

  // trainer model: kind 0 done, 1 fail, 2 no answer; answers in waiting cycle dly
  always @(negedge clk) begin
    trn_done = 0;
    trn_fail = 0;
    if (trn_start) begin
      if (nlog < 8) log_s[nlog] = int'(trn_step);
      nlog++;
      pend = 1; k = 1; cur = int'(trn_step);
    end else if (pend) k++;
    if (pend && kind[cur] != 2 && k == dly) begin
      if (kind[cur] == 1) trn_fail = 1; else trn_done = 1;
      pend = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_we();
    @(negedge clk) cmd_we = 1;
    @(negedge clk) cmd_we = 0;
    cmd_start = 0; cmd_zq = 0; cmd_rcomp = 0; cmd_fifo_rst = 0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 3000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_case(input logic [3:0] m, input logic sof, input logic ard,
                          input int t, input string tag);
    int teff, ecyc, en, cyc;
    int elog [4];
    logic [3:0] efail;
    bit ehalt, stop, ok;
    teff = (t == 0) ? 255 : t;
    ecyc = 0; en = 0; efail = 0; ehalt = 0; stop = 0;
    for (int i = 0; i < 4; i++) begin
      if (!stop) begin
        if (m[i]) ecyc += 1;
        else begin
          elog[en] = i; en++;
          if (kind[i] != 2 && dly <= teff) begin
            ecyc += 1 + dly;
            if (kind[i] == 1) efail[i] = 1;
          end else begin
            ecyc += 1 + teff;
            efail[i] = 1;
            if (sof && !ard) begin ehalt = 1; stop = 1; end
          end
        end
      end
    end
    nlog = 0;
    cmd_skip = m; cmd_stop_on_fail = sof; auto_rst_dis = ard;
    cmd_timeout = TW'(t); cmd_start = 1;
    pulse_we();
    wait_idle(cyc);
    ok = (nlog == en);
    for (int i = 0; i < 4; i++) if (i < en && ok && log_s[i] != elog[i]) ok = 0;
    chk(ok, "R2/R3", {tag, " launch order/count"}, nlog, en);
    chk(step_fail == efail, "R6", {tag, " step_fail"}, step_fail, efail);
    chk(halted == ehalt, "R5", {tag, " halted"}, halted, ehalt);
    chk(cyc == ecyc, "R7", {tag, " busy cycles"}, cyc, ecyc);
  endtask

  initial begin
    #(200000 * 10);
    fails++; tests++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    for (int i = 0; i < 4; i++) kind[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rx_valid_in = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !halted && step_fail == 0, "R1", "status after reset", {busy, halted, step_fail}, 0);
    chk(!trn_start && !zq_req && !rcomp_req && !fifo_rst, "R1", "pulses after reset", {trn_start, zq_req, rcomp_req, fifo_rst}, 0);
    chk(!cke_oe && cke == 0, "R1", "cke after reset", {cke_oe, cke}, 0);
    chk(rx_valid_out == 1, "R1", "rx valid after reset", rx_valid_out, 1);

    // R2/R3 sweep over all skip masks, R4 response in the last allowed cycle
    dly = 2;
    for (int m = 0; m < 16; m++) run_case(4'(m), 0, 0, 4, "sweep");
    dly = 4;
    run_case(4'h0, 1, 0, 4, "R4 edge accepted");
    dly = 5;
    for (int i = 0; i < 4; i++) kind[i] = 0;
    run_case(4'h0, 0, 0, 4, "R4 late response timeout");
    // R6 fail responses on chosen steps
    dly = 3;
    kind[1] = 1; kind[3] = 1;
    run_case(4'h0, 1, 0, 6, "R6 fail resp");
    run_case(4'h2, 1, 0, 6, "R6 fail resp masked");
    for (int i = 0; i < 4; i++) kind[i] = 0;
    // R5 / R6 timeout behaviour
    kind[1] = 2;
    run_case(4'h0, 0, 0, 3, "R6 timeout no sof");
    run_case(4'h0, 1, 1, 3, "R6 timeout ard");
    run_case(4'h0, 1, 0, 3, "R5 halt");
    run_case(4'h1, 1, 0, 2, "R5 halt masked0");
    kind[1] = 0; kind[3] = 2;
    run_case(4'h0, 1, 0, 0, "R4 zero timeout max");
    kind[3] = 0;
    run_case(4'h0, 0, 0, 2, "R7 clears halted");

    // R7 start while busy ignored
    dly = 3; nlog = 0;
    cmd_skip = 0; cmd_timeout = 8; cmd_stop_on_fail = 0; cmd_start = 1;
    pulse_we();
    repeat (2) @(negedge clk);
    cmd_skip = 4'hF; cmd_start = 1;
    pulse_we();
    wait_idle(cyc);
    chk(nlog == 4 && log_s[0] == 0 && log_s[3] == 3, "R7", "start while busy ignored", nlog, 4);

    // R8 calibration requests
    cmd_rank = 2'd2; cmd_zq = 1;
    pulse_we();
    chk(zq_req && !rcomp_req && cal_rank == 2, "R8", "zq pulse", {zq_req, rcomp_req, cal_rank}, {2'b10, 2'd2});
    @(negedge clk);
    chk(!zq_req, "R8", "zq one cycle", zq_req, 0);
    cmd_rank = 2'd3; cmd_rcomp = 1;
    pulse_we();
    chk(rcomp_req && !zq_req && cal_rank == 3, "R8", "rcomp pulse", {zq_req, rcomp_req, cal_rank}, {2'b01, 2'd3});
    @(negedge clk);
    chk(!rcomp_req, "R8", "rcomp one cycle", rcomp_req, 0);

    // R9 fifo reset
    cmd_fifo_rst = 1;
    pulse_we();
    chk(fifo_rst, "R9", "fifo reset pulse", fifo_rst, 1);
    @(negedge clk);
    chk(!fifo_rst, "R9", "fifo reset one cycle", fifo_rst, 0);

    // R10 rx gating
    cmd_ignore_rx = 1;
    pulse_we();
    chk(rx_valid_out == 0, "R10", "rx gated", rx_valid_out, 0);
    cmd_ignore_rx = 0;
    pulse_we();
    chk(rx_valid_out == 1, "R10", "rx passes", rx_valid_out, 1);

    // R11 cke control and lockout
    cmd_cke = 1;
    pulse_we();
    chk(cke_oe && cke == '1, "R11", "cke driven high", {cke_oe, cke}, 3'b111);
    init_done = 1; cmd_cke = 0;
    pulse_we();
    chk(cke_oe && cke == '1, "R11", "cke locked on", {cke_oe, cke}, 3'b111);
    init_done = 0;
    pulse_we();
    chk(!cke_oe && cke == 0, "R11", "cke released", {cke_oe, cke}, 0);
    init_done = 1; cmd_cke = 1;
    pulse_we();
    chk(!cke_oe && cke == 0, "R11", "cke locked off", {cke_oe, cke}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule